// File: doc/BRIEF.md
# Dual-Channel PWM Register Controller

This block is the register-mapped control and output stage of a two-channel pulse-width modulator. A plain 32-bit register bus (byte address, write enable, write data, registered read data) programs one shared control register, one shared output-select register and, for each channel, a 16-bit frequency word (split into two byte registers), an on-time and a period. Software tunes a channel's base rate through the frequency word, shapes the pulse through on-time and period, and enables the channel through its control field.

Each channel contains two generators. The variable-frequency generator is a 16-bit phase accumulator whose top bit is a square-ish tone. The constant-frequency generator counts rising edges of that tone and produces a pulse whose high time and period are set in tone cycles. A registered pad stage picks one of the two signals, can override it with a constant high, and drives the pad output, output enable and open-drain indication in either push-pull or open-drain style.

Top module: `pwm_dual_ctrl`

## Requirements
- R1: After reset every register reads as zero and every pad output, output enable and open-drain indication is low.
- R2: The control register sits at byte address 0x00; channel c owns bits 4c+3..4c with bit 4c = run, 4c+1 = output-disable, 4c+2 = force-high, 4c+3 = open-drain; bits 31..8 read as zero.
- R3: The select register sits at 0x04; bit 4c chooses the constant-frequency pulse for channel c when 1 and the raw tone when 0; all other bits read as zero.
- R4: Channel c has 8-bit registers at: frequency-word high byte 0x08+8c, low byte 0x0C+8c, on-time 0x18+8c, period 0x1C+8c; bits 31..8 read as zero.
- R5: Read data appears one clock after the address is presented; an unmapped address reads zero.
- R6: While run is set, the tone accumulator adds the 16-bit frequency word every clock and the tone is its top bit; while run is clear the accumulator is held at zero and the tone low.
- R7: The constant-frequency pulse advances one step per rising tone edge; a period value p gives p+1 steps, the pulse is high during the first on-time steps, on-time 0 keeps it low and on-time greater than period keeps it high.
- R8: With output-disable set, the pad output enable and pad output are both low.
- R9: With force-high set, the chosen signal is replaced by a constant 1.
- R10: With open-drain set, the pad output is always low and the output enable is the inverse of the level, so a high level is produced by releasing the pad; the open-drain indication follows the control bit.
- R11: The two channels are configured and run independently.
- R12: Pad outputs are registered, one clock behind the generator signals and control bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, data taken at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| pwm_o | output | 2 | Pad output level per channel |
| pwm_oe | output | 2 | Pad output enable per channel |
| pwm_od | output | 2 | Open-drain mode indication per channel |

## Verification
The hardest situation to reach is a checked duty cycle through the constant-frequency path, because its step rate depends on the tone edges and its phase on when run was set. The stimulus picks frequency words that are powers of two so that the tone period is an exact number of clocks, then counts high cycles over a window that is a whole multiple of the pulse period, which makes the count independent of phase. The same counting exposes open-drain behaviour through the output enable and shows that the second channel keeps its own rate while the first is reconfigured.

// File: rtl/pwm_dual_pkg.sv
package pwm_dual_pkg;
  localparam int CH_NUM   = 2;
  localparam int FIELD_W  = 4;
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 16;

  typedef struct packed {
    logic od;
    logic force_hi;
    logic oeb;
    logic run;
  } ch_ctrl_t;

  localparam logic [5:0] A_CTRL = 6'h00;
  localparam logic [5:0] A_SEL  = 6'h04;

  function automatic logic [5:0] a_whi(input int c); return 6'(8'h08 + 8 * c); endfunction
  function automatic logic [5:0] a_wlo(input int c); return 6'(8'h0C + 8 * c); endfunction
  function automatic logic [5:0] a_on (input int c); return 6'(8'h18 + 8 * c); endfunction
  function automatic logic [5:0] a_per(input int c); return 6'(8'h1C + 8 * c); endfunction
endpackage

// File: rtl/pwm_vfreq.sv
module pwm_vfreq #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [ACC_W-1:0] word_i,
  output logic             tone_o,
  output logic             tick_o
);
  logic [ACC_W-1:0] acc_q;
  logic             tone_d_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) acc_q <= '0;
    else               acc_q <= acc_q + word_i;
    if (rst) tone_d_q <= 1'b0;
    else     tone_d_q <= acc_q[ACC_W-1];
  end

  assign tone_o = acc_q[ACC_W-1];
  assign tick_o = acc_q[ACC_W-1] & ~tone_d_q;

  assert_idle_tone_R6: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !tone_o);
endmodule

// File: rtl/pwm_cfreq.sv
module pwm_cfreq #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] on_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             pulse_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      if (tick_i) cnt_q <= (cnt_q >= period_i) ? '0 : cnt_q + 1'b1;
      pulse_o <= (cnt_q < on_i);
    end
  end

  assert_on_zero_low_R7: assert property (@(posedge clk) disable iff (rst)
    (on_i == '0) |=> !pulse_o);
endmodule

// File: rtl/pwm_pad.sv
module pwm_pad (
  input  logic                   clk,
  input  logic                   rst,
  input  pwm_dual_pkg::ch_ctrl_t ctrl_i,
  input  logic                   sel_const_i,
  input  logic                   tone_i,
  input  logic                   pulse_i,
  output logic                   out_o,
  output logic                   oe_o,
  output logic                   od_o
);
  logic level;

  always_comb begin
    level = ctrl_i.force_hi ? 1'b1 : (sel_const_i ? pulse_i : tone_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_o <= 1'b0;
      oe_o  <= 1'b0;
      od_o  <= 1'b0;
    end else begin
      od_o <= ctrl_i.od;
      if (ctrl_i.oeb) begin
        out_o <= 1'b0;
        oe_o  <= 1'b0;
      end else if (ctrl_i.od) begin
        out_o <= 1'b0;
        oe_o  <= ~level;
      end else begin
        out_o <= level;
        oe_o  <= 1'b1;
      end
    end
  end

  assert_oeb_float_R8: assert property (@(posedge clk) disable iff (rst)
    ctrl_i.oeb |=> (!oe_o && !out_o));
  assert_force_high_R9: assert property (@(posedge clk) disable iff (rst)
    (ctrl_i.force_hi && !ctrl_i.oeb && !ctrl_i.od) |=> (out_o && oe_o));
  assert_od_no_high_R10: assert property (@(posedge clk) disable iff (rst)
    ctrl_i.od |=> !out_o);
endmodule

// File: rtl/pwm_dual_ctrl.sv
module pwm_dual_ctrl #(
  parameter int CH_NUM = pwm_dual_pkg::CH_NUM,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int BYTE_W = pwm_dual_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [CH_NUM-1:0] pwm_o,
  output logic [CH_NUM-1:0] pwm_oe,
  output logic [CH_NUM-1:0] pwm_od
);
  import pwm_dual_pkg::*;

  localparam int CTRL_W = CH_NUM * FIELD_W;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CH_NUM-1:0] sel_q;
  logic [BYTE_W-1:0] whi_q [CH_NUM];
  logic [BYTE_W-1:0] wlo_q [CH_NUM];
  logic [BYTE_W-1:0] on_q  [CH_NUM];
  logic [BYTE_W-1:0] per_q [CH_NUM];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      sel_q  <= '0;
    end else if (bus_we) begin
      if (bus_addr == A_CTRL) ctrl_q <= bus_wdata[CTRL_W-1:0];
      if (bus_addr == A_SEL)
        for (int c = 0; c < CH_NUM; c++) sel_q[c] <= bus_wdata[c*FIELD_W];
    end
  end

  logic [DATA_W-1:0] rd_next;
  logic              mapped;

  always_comb begin
    rd_next = '0;
    mapped  = 1'b0;
    if (bus_addr == A_CTRL) begin
      rd_next[CTRL_W-1:0] = ctrl_q;
      mapped = 1'b1;
    end
    if (bus_addr == A_SEL) begin
      for (int c = 0; c < CH_NUM; c++) rd_next[c*FIELD_W] = sel_q[c];
      mapped = 1'b1;
    end
    for (int c = 0; c < CH_NUM; c++) begin
      if (bus_addr == a_whi(c)) begin rd_next[BYTE_W-1:0] = whi_q[c]; mapped = 1'b1; end
      if (bus_addr == a_wlo(c)) begin rd_next[BYTE_W-1:0] = wlo_q[c]; mapped = 1'b1; end
      if (bus_addr == a_on(c))  begin rd_next[BYTE_W-1:0] = on_q[c];  mapped = 1'b1; end
      if (bus_addr == a_per(c)) begin rd_next[BYTE_W-1:0] = per_q[c]; mapped = 1'b1; end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  for (genvar g = 0; g < CH_NUM; g++) begin : g_ch
    ch_ctrl_t         ctl;
    logic             tone, tick, pulse;
    logic [2*BYTE_W-1:0] word;

    always_ff @(posedge clk) begin
      if (rst) begin
        whi_q[g] <= '0;
        wlo_q[g] <= '0;
        on_q[g]  <= '0;
        per_q[g] <= '0;
      end else if (bus_we) begin
        if (bus_addr == a_whi(g)) whi_q[g] <= bus_wdata[BYTE_W-1:0];
        if (bus_addr == a_wlo(g)) wlo_q[g] <= bus_wdata[BYTE_W-1:0];
        if (bus_addr == a_on(g))  on_q[g]  <= bus_wdata[BYTE_W-1:0];
        if (bus_addr == a_per(g)) per_q[g] <= bus_wdata[BYTE_W-1:0];
      end
    end

    assign ctl  = ctrl_q[g*FIELD_W +: FIELD_W];
    assign word = {whi_q[g], wlo_q[g]};

    pwm_vfreq #(.ACC_W(2*BYTE_W)) u_vf (
      .clk(clk), .rst(rst), .run_i(ctl.run), .word_i(word),
      .tone_o(tone), .tick_o(tick));

    pwm_cfreq #(.CNT_W(BYTE_W)) u_cf (
      .clk(clk), .rst(rst), .run_i(ctl.run), .tick_i(tick),
      .on_i(on_q[g]), .period_i(per_q[g]), .pulse_o(pulse));

    pwm_pad u_pad (
      .clk(clk), .rst(rst), .ctrl_i(ctl), .sel_const_i(sel_q[g]),
      .tone_i(tone), .pulse_i(pulse),
      .out_o(pwm_o[g]), .oe_o(pwm_oe[g]), .od_o(pwm_od[g]));
  end

  assert_unmapped_zero_R5: assert property (@(posedge clk) disable iff (rst)
    !mapped |=> (bus_rdata == '0));
endmodule

// File: tb/pwm_dual_ctrl_tb.sv
module pwm_dual_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  pwm_o, pwm_oe, pwm_od;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct {
    int          due;
    logic [31:0] exp;
    string       tag;
  } rd_item_t;
  rd_item_t exp_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwm_dual_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_o(pwm_o), .pwm_oe(pwm_oe), .pwm_od(pwm_od));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compares read data one clock after the address was driven
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
      rd_item_t it;
      it = exp_q.pop_front();
      check(it.tag, bus_rdata, it.exp);
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
    rd_item_t it;
    @(negedge clk);
    bus_addr = a;
    it.due = cyc + 1; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic flush();
    repeat (3) @(negedge clk);
  endtask

  task automatic count(input int ch, input bit use_oe, output int n);
    n = 0;
    repeat (20) @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      n += use_oe ? int'(pwm_oe[ch]) : int'(pwm_o[ch]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 pwm_o", {30'd0, pwm_o}, 32'd0);
    check("R1 pwm_oe", {30'd0, pwm_oe}, 32'd0);
    check("R1 pwm_od", {30'd0, pwm_od}, 32'd0);
    rd(6'h00, 0, "R1 ctrl"); rd(6'h04, 0, "R1 sel");
    rd(6'h08, 0, "R1 whi0"); rd(6'h24, 0, "R1 per1");
    flush();

    // R2 R3 R4 R5 register widths and addresses
    wr(6'h00, 32'hFFFF_FFFF); rd(6'h00, 32'h0000_00FF, "R2 ctrl width");
    wr(6'h04, 32'hFFFF_FFFF); rd(6'h04, 32'h0000_0011, "R3 sel bits");
    wr(6'h08, 32'h0000_1234); rd(6'h08, 32'h34, "R4 whi0");
    wr(6'h0C, 32'h0000_0156); rd(6'h0C, 32'h56, "R4 wlo0");
    wr(6'h10, 32'h78);        rd(6'h10, 32'h78, "R4 whi1");
    wr(6'h14, 32'h9A);        rd(6'h14, 32'h9A, "R4 wlo1");
    wr(6'h18, 32'h11);        rd(6'h18, 32'h11, "R4 on0");
    wr(6'h1C, 32'h22);        rd(6'h1C, 32'h22, "R4 per0");
    wr(6'h20, 32'h33);        rd(6'h20, 32'h33, "R4 on1");
    wr(6'h24, 32'h44);        rd(6'h24, 32'h44, "R4 per1");
    wr(6'h28, 32'hFF);        rd(6'h28, 32'h0, "R5 unmapped 0x28");
    rd(6'h3C, 32'h0, "R5 unmapped 0x3C");
    rd(6'h02, 32'h0, "R5 unmapped 0x02");
    rd(6'h1C, 32'h22, "R5 back-to-back read");
    flush();
    wr(6'h00, 32'h0000_0022); // both channels disabled, outputs off

    // R8 output-disable
    repeat (3) @(negedge clk);
    check("R8 oe low", {30'd0, pwm_oe}, 32'd0);
    check("R8 out low", {30'd0, pwm_o}, 32'd0);

    // R6 raw tone on channel 0: word 0x4000 -> 4-clock tone, half high
    wr(6'h04, 32'h0);
    wr(6'h08, 32'h40); wr(6'h0C, 32'h00);
    wr(6'h00, 32'h0000_0021);
    count(0, 0, n); check("R6 tone word 0x4000 highs", n, 32);
    count(0, 1, n); check("R12 push-pull oe steady", n, 64);
    // R6 word 0x2000 -> still half high
    wr(6'h08, 32'h20);
    count(0, 0, n); check("R6 tone word 0x2000 highs", n, 32);
    // R6 run clear holds tone low while pad enabled
    wr(6'h00, 32'h0000_0020);
    count(0, 0, n); check("R6 run clear tone low", n, 0);

    // R7 constant pulse: word 0x8000 (tick every 2 clocks), period 3, on 1
    wr(6'h08, 32'h80); wr(6'h18, 32'h01); wr(6'h1C, 32'h03);
    wr(6'h04, 32'h0000_0001);
    wr(6'h00, 32'h0000_0021);
    count(0, 0, n); check("R7 on1 per3 highs", n, 16);
    wr(6'h18, 32'h02);
    count(0, 0, n); check("R7 on2 per3 highs", n, 32);
    wr(6'h18, 32'h00);
    count(0, 0, n); check("R7 on0 always low", n, 0);
    wr(6'h18, 32'hFF); wr(6'h1C, 32'hFE);
    count(0, 0, n); check("R7 on>period always high", n, 64);
    // R3 select back to raw tone
    wr(6'h04, 32'h0);
    count(0, 0, n); check("R3 raw tone selected", n, 32);

    // R9 force high
    wr(6'h00, 32'h0000_0025);
    count(0, 0, n); check("R9 force high", n, 64);

    // R10 open drain, raw tone word 0x4000
    wr(6'h08, 32'h40);
    wr(6'h00, 32'h0000_0029);
    count(0, 0, n); check("R10 od out never high", n, 0);
    count(0, 1, n); check("R10 od oe inverse", n, 32);
    check("R10 od flag", {30'd0, pwm_od}, 32'd1);
    wr(6'h00, 32'h0000_002D);
    count(0, 1, n); check("R10 od force high releases", n, 0);

    // R11 channel 1 independent: constant pulse on1 per3 word 0x8000
    wr(6'h10, 32'h80); wr(6'h14, 32'h00);
    wr(6'h20, 32'h01); wr(6'h24, 32'h03);
    wr(6'h04, 32'h0000_0010);
    wr(6'h00, 32'h0000_0011);
    count(1, 0, n); check("R11 ch1 pulse highs", n, 16);
    count(0, 0, n); check("R11 ch0 tone unaffected", n, 32);
    wr(6'h00, 32'h0000_0021);
    count(1, 0, n); check("R11 ch1 disabled", n, 0);
    count(0, 0, n); check("R11 ch0 still running", n, 32);

    flush();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule